// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, called A and B, and can carry data across in either direction. Each direction has a storage register of its own, loaded by a capture strobe of its own. A per-direction source select sends either live data from the opposite bus or that direction's stored word. Two enables decide whether the block drives the B side, the A side, both, or neither. The enable for B is active high and the enable for A is active low.

Each bus appears as split vectors. An input vector carries the data of an external driver. A valid flag says whether that external driver is present. An output vector and an output enable carry what the block drives. On a bus, an external driver always wins. Otherwise the block's own drive sets the bus. With neither present, the bus keeps its previous value in a hold register clocked by the system clock.

If both sides are driven in real-time mode, the outputs form a loop that keeps itself alive. It passes whatever an external driver puts on either bus to the other bus. When both buses go quiet, each keeps the value it last had. The capture strobes are sampled on the system clock, and the design looks for their rising edges there. A rising strobe loads the register no matter what the selects and enables are set to.

Top module: `regbus_xcvr`

## Requirements
- R1: An active-low asynchronous reset clears both storage registers and both hold registers to 0. After reset, with both sides driving stored data, both outputs read 0x00.
- R2: A rising edge of `cap_ab`, seen on a system-clock edge, loads the value on the A bus into the A-to-B register. This happens for every setting of the selects and enables. The new value can be seen from the next cycle on.
- R3: A rising edge of `cap_ba`, seen on a system-clock edge, loads the value on the B bus into the B-to-A register. This happens for every setting of the selects and enables.
- R4: A strobe that stays high, or stays low, leaves its register unchanged, even when the bus data changes.
- R5: With `b_en`=0 and `a_en_n`=1, both output enables are 0 and both output vectors are 0x00.
- R6: With `b_en`=0 and `a_en_n`=0, only A drives. When `sel_ba`=0, `a_out` carries the live B bus. When `sel_ba`=1, it carries the B-to-A register.
- R7: With `b_en`=1 and `a_en_n`=1, only B drives. When `sel_ab`=0, `b_out` carries the live A bus. When `sel_ab`=1, it carries the A-to-B register.
- R8: With `b_en`=1, `a_en_n`=0 and both selects at 1, `a_out` shows the B-to-A register and `b_out` shows the A-to-B register, both in the same cycle.
- R9: With both sides driving and only one select at 0, the real-time side shows the stored word that the other side is driving.
- R10: With both sides driving and both selects at 0, an external driver on either bus shows up on both outputs. When neither bus has an external driver, each bus keeps its last value.
- R11: A bus that has no external driver and is not driven by the block keeps its last value. This can be seen by capturing the bus later.
- R12: Capturing a bus while the block drives it from storage loads the value the block is driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for strobe sampling and bus hold |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_ab | input | 1 | A-to-B capture strobe; its rising edge loads the register |
| cap_ba | input | 1 | B-to-A capture strobe; its rising edge loads the register |
| sel_ab | input | 1 | B-side source: 0 = live A, 1 = A-to-B register |
| sel_ba | input | 1 | A-side source: 0 = live B, 1 = B-to-A register |
| b_en | input | 1 | Drive enable for the B side, active high |
| a_en_n | input | 1 | Drive enable for the A side, active low |
| a_in | input | W | Data of the external driver on A |
| a_in_vld | input | 1 | An external driver is present on A |
| b_in | input | W | Data of the external driver on B |
| b_in_vld | input | 1 | An external driver is present on B |
| a_out | output | W | Data the block drives onto A (0 when not driving) |
| a_oe | output | 1 | The block drives A |
| b_out | output | W | Data the block drives onto B (0 when not driving) |
| b_oe | output | 1 | The block drives B |

## Verification
The assertions assume that the strobes, selects, enables and external-driver flags all change only between system-clock edges. They also assume an external driver simply overrides the block's drive, so no bus is ever left undefined. The bench sets every input half a period away from the active edge. Its random phase may set both valid flags together, which is legal under the override rule. It checks each cycle against a behavioural model, and it also holds strobes high for several cycles so that the edge-only capture rule is tested.

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         b_en,
  input  logic         a_en_n,
  input  logic [W-1:0] a_in,
  input  logic         a_in_vld,
  input  logic [W-1:0] b_in,
  input  logic         b_in_vld,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  logic [W-1:0] reg_ab, reg_ba, a_hold, b_hold;
  logic [W-1:0] a_bus, b_bus, a_eh, b_eh, a_rt, b_rt;
  logic         cap_ab_q, cap_ba_q, run_q, loop;
  logic         ab_fire, ba_fire;

  assign a_oe = ~a_en_n;
  assign b_oe = b_en;
  assign loop = a_oe & b_oe & ~sel_ab & ~sel_ba;

  assign a_eh = a_in_vld ? a_in : a_hold;
  assign b_eh = b_in_vld ? b_in : b_hold;

  assign a_rt = loop ? (b_in_vld ? b_in : a_eh)
                     : (b_in_vld ? b_in : ((b_oe & sel_ab) ? reg_ab : b_hold));
  assign b_rt = loop ? (a_in_vld ? a_in : b_eh)
                     : (a_in_vld ? a_in : ((a_oe & sel_ba) ? reg_ba : a_hold));

  assign a_out = !a_oe ? '0 : (sel_ba ? reg_ba : a_rt);
  assign b_out = !b_oe ? '0 : (sel_ab ? reg_ab : b_rt);

  assign a_bus = a_in_vld ? a_in : (a_oe ? a_out : a_hold);
  assign b_bus = b_in_vld ? b_in : (b_oe ? b_out : b_hold);

  assign ab_fire = cap_ab & ~cap_ab_q;
  assign ba_fire = cap_ba & ~cap_ba_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_ab   <= '0;
      reg_ba   <= '0;
      a_hold   <= '0;
      b_hold   <= '0;
      cap_ab_q <= 1'b0;
      cap_ba_q <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      cap_ab_q <= cap_ab;
      cap_ba_q <= cap_ba;
      run_q    <= 1'b1;
      a_hold   <= a_bus;
      b_hold   <= b_bus;
      if (ab_fire) reg_ab <= a_bus;
      if (ba_fire) reg_ba <= b_bus;
    end
  end

  assert_cap_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ab && !cap_ab_q) |=> (reg_ab == $past(a_bus)));

  assert_cap_ba_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ba && !cap_ba_q) |=> (reg_ba == $past(b_bus)));

  assert_no_cap_ab_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_ab && !cap_ab_q) |=> $stable(reg_ab));

  assert_no_cap_ba_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_ba && !cap_ba_q) |=> $stable(reg_ba));

  assert_loop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && loop && !a_in_vld && !b_in_vld) |->
      (a_bus == $past(a_bus)) && (b_bus == $past(b_bus)));

  assert_idle_hold_a_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !a_in_vld && !a_oe) |-> (a_bus == $past(a_bus)));

  assert_idle_hold_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !b_in_vld && !b_oe) |-> (b_bus == $past(b_bus)));

endmodule

// File: tb/regbus_xcvr_tb.sv
`timescale 1ns/1ps
module regbus_xcvr_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cap_ab = 0, cap_ba = 0, sel_ab = 0, sel_ba = 0, b_en = 0, a_en_n = 1;
  logic [7:0] a_in = 0, b_in = 0;
  logic a_in_vld = 0, b_in_vld = 0;
  logic [7:0] a_out, b_out;
  logic a_oe, b_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur = "R1";

  logic [7:0] m_rab = 0, m_rba = 0, m_ah = 0, m_bh = 0;
  logic m_qab = 0, m_qba = 0;
  logic [7:0] e_ao, e_bo, e_abus, e_bbus;
  logic e_aoe, e_boe;

  always #4 clk = ~clk;

  regbus_xcvr #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .b_en(b_en), .a_en_n(a_en_n),
    .a_in(a_in), .a_in_vld(a_in_vld), .b_in(b_in), .b_in_vld(b_in_vld),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

  task automatic model();
    logic [7:0] a_side, b_side;
    e_aoe = !a_en_n;
    e_boe = b_en;
    if (e_aoe && e_boe && !sel_ab && !sel_ba) begin
      e_ao = b_in_vld ? b_in : (a_in_vld ? a_in : m_ah);
      e_bo = a_in_vld ? a_in : (b_in_vld ? b_in : m_bh);
    end else begin
      a_side = a_in_vld ? a_in : ((e_aoe && sel_ba) ? m_rba : m_ah);
      b_side = b_in_vld ? b_in : ((e_boe && sel_ab) ? m_rab : m_bh);
      e_ao = !e_aoe ? 8'h00 : (sel_ba ? m_rba : b_side);
      e_bo = !e_boe ? 8'h00 : (sel_ab ? m_rab : a_side);
    end
    e_abus = a_in_vld ? a_in : (e_aoe ? e_ao : m_ah);
    e_bbus = b_in_vld ? b_in : (e_boe ? e_bo : m_bh);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rab = 0; m_rba = 0; m_ah = 0; m_bh = 0; m_qab = 0; m_qba = 0;
    end else begin
      model();
      if (cap_ab && !m_qab) m_rab = e_abus;
      if (cap_ba && !m_qba) m_rba = e_bbus;
      m_qab = cap_ab; m_qba = cap_ba;
      m_ah = e_abus; m_bh = e_bbus;
    end
  end

  task automatic expect8(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    #1;
    model();
    expect8(cur, "a_out", a_out, e_ao);
    expect8(cur, "b_out", b_out, e_bo);
    expect8(cur, "a_oe", {7'd0, a_oe}, {7'd0, e_aoe});
    expect8(cur, "b_oe", {7'd0, b_oe}, {7'd0, e_boe});
  endtask

  task automatic adv();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    adv();
    // R1: reset state seen through stored mode on both sides
    cur = "R1"; b_en = 1; a_en_n = 0; sel_ab = 1; sel_ba = 1; settle();
    expect8("R1", "a_out", a_out, 8'h00); expect8("R1", "b_out", b_out, 8'h00); adv();
    // R5: nothing driven
    cur = "R5"; b_en = 0; a_en_n = 1; settle();
    expect8("R5", "oe", {6'd0, a_oe, b_oe}, 8'h00);
    expect8("R5", "a_out", a_out, 8'h00); expect8("R5", "b_out", b_out, 8'h00); adv();
    // R2: capture A bus
    cur = "R2"; a_in = 8'hA5; a_in_vld = 1; settle(); adv();
    cap_ab = 1; settle(); adv();
    b_en = 1; settle(); expect8("R2", "b_out", b_out, 8'hA5); adv();
    // R4: strobe held high, data changes
    cur = "R4"; a_in = 8'h3C; settle(); adv(); settle(); adv();
    settle(); expect8("R4", "b_out", b_out, 8'hA5); adv();
    cap_ab = 0; b_en = 0;
    // R3: capture B bus
    cur = "R3"; b_in = 8'hC3; b_in_vld = 1; a_in_vld = 0; settle(); adv();
    cap_ba = 1; settle(); adv();
    a_en_n = 0; b_in = 8'h00; settle(); expect8("R3", "a_out", a_out, 8'hC3); adv();
    // R6: A drives only
    cur = "R6"; sel_ba = 0; b_in = 8'h77; settle();
    expect8("R6", "a_out live", a_out, 8'h77);
    expect8("R6", "oe", {6'd0, a_oe, b_oe}, 8'h02); adv();
    sel_ba = 1; settle(); expect8("R6", "a_out stored", a_out, 8'hC3); adv();
    // R7: B drives only
    cur = "R7"; a_en_n = 1; b_en = 1; b_in_vld = 0; sel_ab = 0; a_in = 8'h11; a_in_vld = 1;
    settle(); expect8("R7", "b_out live", b_out, 8'h11); adv();
    sel_ab = 1; settle(); expect8("R7", "b_out stored", b_out, 8'hA5); adv();
    // R8: both stored
    cur = "R8"; a_in_vld = 0; a_en_n = 0; settle();
    expect8("R8", "a_out", a_out, 8'hC3); expect8("R8", "b_out", b_out, 8'hA5); adv();
    // R9 and R12: A real-time sees B stored, then capture the driven B bus
    cur = "R9"; cap_ba = 0; sel_ba = 0; settle();
    expect8("R9", "a_out", a_out, 8'hA5); adv();
    cur = "R12"; cap_ba = 1; settle(); adv();
    sel_ba = 1; settle(); expect8("R12", "a_out", a_out, 8'hA5); adv();
    cap_ba = 0;
    // R10: self-holding loop
    cur = "R10"; sel_ab = 0; sel_ba = 0; a_in = 8'h9E; a_in_vld = 1; settle();
    expect8("R10", "b_out", b_out, 8'h9E); expect8("R10", "a_out", a_out, 8'h9E); adv();
    a_in_vld = 0; for (int i = 0; i < 3; i++) begin settle(); adv(); end
    settle(); expect8("R10", "a_out hold", a_out, 8'h9E); expect8("R10", "b_out hold", b_out, 8'h9E); adv();
    b_in = 8'h42; b_in_vld = 1; settle(); expect8("R10", "a_out", a_out, 8'h42); adv();
    b_in_vld = 0; settle(); adv(); settle();
    expect8("R10", "a_out hold", a_out, 8'h42); expect8("R10", "b_out hold", b_out, 8'h42); adv();
    // R11: undriven A bus keeps its value, seen by a late capture
    cur = "R11"; b_en = 0; a_en_n = 1; a_in = 8'h66; a_in_vld = 1; settle(); adv();
    a_in_vld = 0; a_in = 8'h00; for (int i = 0; i < 3; i++) begin settle(); adv(); end
    cap_ab = 1; settle(); adv();
    cap_ab = 0; b_en = 1; sel_ab = 1; settle(); expect8("R11", "b_out", b_out, 8'h66); adv();
    // Random sweep across all controls (R2..R12 against the model)
    cur = "R2-sweep";
    for (int n = 0; n < 3000; n++) begin
      cur = (n % 2 == 0) ? "R2" : "R10";
      cap_ab = $urandom_range(0, 1); cap_ba = $urandom_range(0, 1);
      sel_ab = $urandom_range(0, 1); sel_ba = $urandom_range(0, 1);
      b_en = $urandom_range(0, 1); a_en_n = $urandom_range(0, 1);
      a_in = 8'($urandom); b_in = 8'($urandom);
      a_in_vld = ($urandom_range(0, 3) == 0); b_in_vld = ($urandom_range(0, 3) == 0);
      settle(); adv();
    end
    finish_run();
  end
endmodule